// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer with Manual CDR Lock

This controller brings a group of serial transceiver channels out of power-up in a safe order. It holds the transmit PLL in power-down for a minimum time, then waits for that PLL to lock before releasing the transmit digital resets. On the receive side it waits for the reconfiguration engine to go idle and then releases the analog reset. It keeps each clock-data-recovery unit tracking the reference clock until its receive PLL has been locked for a dwell time. It then switches the unit to track the incoming data. The receive digital reset is released only after a second dwell.

In bonded mode one shared receive sequence drives every channel. That sequence waits for the last channel's receive PLL to lock. In non-bonded mode each channel runs its own copy of the receive sequence. All dwell times are set in microseconds and turned into clock counts from a clock-frequency parameter. The conversion rounds up. The lock and busy inputs are asynchronous and pass through two-flop synchronizers. Reset is synchronous and active high.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is high and for exactly PD_CYC rising edges after it is released, `txpll_pd_o` is high. It is then low. It rises again only on a transmit-lock loss (R11).
- R2: While `txpll_pd_o` is high, every channel holds `tx_rst_o`, `rx_arst_o`, `rx_drst_o` and `cdr_ref_o` at 1 and `cdr_data_o` at 0.
- R3: `tx_rst_o` stays high while the transmit PLL lock is low. It falls on the 3rd rising edge after `txpll_lock_i` rises: two synchronizer stages, then the state update.
- R4: `rx_arst_o` stays high while `cfg_busy_i` is high. It falls on the 5th rising edge after `cfg_busy_i` falls: two synchronizer stages, one edge to see idle, and a two-cycle gap.
- R5: In bonded mode (BONDED=1) the dwell in lock-to-reference starts only when every bit of `rxpll_lock_i` is high. Its timing is taken from the last bit to rise.
- R6: On the (3+REF_CYC)-th rising edge after the last needed receive lock rises, `cdr_ref_o` falls and `cdr_data_o` rises on the same edge.
- R7: `rx_drst_o` falls DATA_CYC rising edges after `cdr_data_o` rises.
- R8: In non-bonded mode (BONDED=0) channel c follows R4 to R7 using only `rxpll_lock_i[c]`. The other channels' locks have no effect on it.
- R9: `seq_done_o[c]` is high exactly when channel c has all of its resets released and the transmit side is running.
- R10: If a needed receive lock falls after the dwell in lock-to-reference has started, the sequence goes back to lock-to-reference on the 3rd edge. There `cdr_ref_o`=1, `cdr_data_o`=0, `rx_drst_o`=1 and `seq_done_o`=0, and `rx_arst_o` stays 0. Other non-bonded channels keep their state.
- R11: If the transmit lock falls while the transmit side is running, on the 3rd edge `txpll_pd_o` rises and every channel returns to the state of R2. The whole sequence then runs again.
- R12: Each delay is ceil(us × CLK_KHZ / 1000) cycles. With CLK_KHZ=2500 this gives PD_CYC=3 for 1 µs, REF_CYC=38 for 15 µs and DATA_CYC=10 for 4 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| txpll_lock_i | input | 1 | Transmit PLL lock, asynchronous |
| cfg_busy_i | input | 1 | Reconfiguration busy flag, asynchronous |
| rxpll_lock_i | input | NUM_CH | Receive PLL lock per channel, asynchronous |
| txpll_pd_o | output | 1 | Transmit PLL power-down |
| tx_rst_o | output | NUM_CH | Transmit digital reset per channel |
| rx_arst_o | output | NUM_CH | Receive analog reset per channel |
| rx_drst_o | output | NUM_CH | Receive digital reset per channel |
| cdr_ref_o | output | NUM_CH | CDR lock-to-reference control |
| cdr_data_o | output | NUM_CH | CDR lock-to-data control |
| seq_done_o | output | NUM_CH | Sequence complete per channel |

## Verification
A bonded instance and a non-bonded instance share one set of stimuli. The receive locks are raised one channel at a time, so a single pattern shows that the bonded sequence waits for the last lock while the non-bonded channel 0 goes ahead alone. Busy is held high past the release of power-down to show that the analog reset waits for idle. A receive lock is dropped and restored on one channel, which separates a per-channel fallback from a group-wide one. Dropping the transmit lock after completion checks that the full restart takes place. The edge counts for each phase are exact, and the 15 µs dwell comes to 37.5 cycles, so an off-by-one or a rounding-down delay is caught.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

    // Transmit-side phases
    typedef enum logic [1:0] {
        TXS_PWRDN,
        TXS_WAIT_LOCK,
        TXS_RUN
    } txs_e;

    // Receive-side phases
    typedef enum logic [2:0] {
        RXS_HOLD,
        RXS_WAIT_IDLE,
        RXS_GAP,
        RXS_WAIT_LOCK,
        RXS_REF_DWELL,
        RXS_DATA_DWELL,
        RXS_DONE
    } rxs_e;

    // Control bundle driven by one receive sequence
    typedef struct packed {
        logic arst;
        logic drst;
        logic cdr_ref;
        logic cdr_data;
        logic done;
    } rx_ctl_t;

    // Parallel-clock cycles between busy idle and analog reset release
    localparam int unsigned GAP_CYC = 2;

    // Microseconds to cycles, rounded up so a delay never falls short
    function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                 input int unsigned us);
        int unsigned c;
        c = (us * khz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/xcvr_sync2.sv
module xcvr_sync2 #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/xcvr_tx_ctrl.sv
module xcvr_tx_ctrl
    import xcvr_rst_pkg::*;
#(
    parameter int unsigned PD_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,     // synchronized transmit PLL lock
    output logic pd_o,       // transmit PLL power-down
    output logic run_o,      // transmit side released
    output logic hold_o      // receive sequences must return to hold
);
    localparam int unsigned CW = cnt_bits(PD_CYC);

    txs_e          state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lost;

    assign lost = (state_q == TXS_RUN) && !lock_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TXS_PWRDN: begin
                if (cnt_q == CW'(PD_CYC - 1)) begin
                    state_d = TXS_WAIT_LOCK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TXS_WAIT_LOCK: begin
                if (lock_i) state_d = TXS_RUN;
            end
            TXS_RUN: begin
                if (lost) begin
                    state_d = TXS_PWRDN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TXS_PWRDN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXS_PWRDN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign pd_o   = (state_q == TXS_PWRDN);
    assign run_o  = (state_q == TXS_RUN);
    assign hold_o = pd_o || lost;

    // R1: power-down is released only after a full count
    a_r1_pd_released_after_count: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_o) |-> $past(cnt_q) == CW'(PD_CYC - 1));

    // R11: a running transmit side with a lost lock is back in power-down next cycle
    a_r11_restart_on_loss: assert property (@(posedge clk) disable iff (rst)
        (run_o && !lock_i) |=> pd_o);
endmodule

// File: rtl/xcvr_rx_lane.sv
module xcvr_rx_lane
    import xcvr_rst_pkg::*;
#(
    parameter int unsigned REF_CYC  = 1875,
    parameter int unsigned DATA_CYC = 500
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_i,   // transmit side restarting
    input  logic    busy_i,   // synchronized reconfiguration busy
    input  logic    lock_i,   // synchronized, combined receive lock
    output rx_ctl_t ctl_o
);
    localparam int unsigned MAXC = max3(REF_CYC, DATA_CYC, GAP_CYC);
    localparam int unsigned CW   = cnt_bits(MAXC);

    rxs_e          state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hold_i) begin
            state_d = RXS_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                RXS_HOLD: state_d = RXS_WAIT_IDLE;
                RXS_WAIT_IDLE: begin
                    if (!busy_i) begin
                        state_d = RXS_GAP;
                        cnt_d   = '0;
                    end
                end
                RXS_GAP: begin
                    if (cnt_q == CW'(GAP_CYC - 1)) begin
                        state_d = RXS_WAIT_LOCK;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RXS_WAIT_LOCK: begin
                    if (lock_i) begin
                        state_d = RXS_REF_DWELL;
                        cnt_d   = '0;
                    end
                end
                RXS_REF_DWELL: begin
                    if (!lock_i) begin
                        state_d = RXS_WAIT_LOCK;
                        cnt_d   = '0;
                    end else if (cnt_q == CW'(REF_CYC - 1)) begin
                        state_d = RXS_DATA_DWELL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RXS_DATA_DWELL: begin
                    if (!lock_i) begin
                        state_d = RXS_WAIT_LOCK;
                        cnt_d   = '0;
                    end else if (cnt_q == CW'(DATA_CYC - 1)) begin
                        state_d = RXS_DONE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RXS_DONE: begin
                    if (!lock_i) begin
                        state_d = RXS_WAIT_LOCK;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = RXS_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ctl_o.arst     = (state_q == RXS_HOLD) || (state_q == RXS_WAIT_IDLE) ||
                         (state_q == RXS_GAP);
        ctl_o.cdr_data = (state_q == RXS_DATA_DWELL) || (state_q == RXS_DONE);
        ctl_o.cdr_ref  = !ctl_o.cdr_data;
        ctl_o.drst     = (state_q != RXS_DONE);
        ctl_o.done     = (state_q == RXS_DONE);
    end

    // R4: analog reset release follows an idle busy seen GAP_CYC edges earlier
    a_r4_arst_after_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_o.arst) |-> !$past(busy_i, GAP_CYC));

    // R6: the switch to data tracking needs the lock held
    a_r6_data_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.cdr_data) |-> $past(lock_i));

    // R7: digital reset is released only from data tracking
    a_r7_drst_after_data: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_o.drst) |-> $past(ctl_o.cdr_data));

    // R10: a missing lock leaves no data tracking on the next cycle
    a_r10_loss_drops_data: assert property (@(posedge clk) disable iff (rst)
        (!lock_i && !hold_i) |=> !ctl_o.cdr_data);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xcvr_rst_pkg::*;
#(
    parameter int unsigned NUM_CH        = 4,
    parameter bit          BONDED        = 1'b1,
    parameter int unsigned CLK_KHZ       = 125000,
    parameter int unsigned PD_US         = 1,
    parameter int unsigned REF_DWELL_US  = 15,
    parameter int unsigned DATA_DWELL_US = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txpll_lock_i,
    input  logic              cfg_busy_i,
    input  logic [NUM_CH-1:0] rxpll_lock_i,
    output logic              txpll_pd_o,
    output logic [NUM_CH-1:0] tx_rst_o,
    output logic [NUM_CH-1:0] rx_arst_o,
    output logic [NUM_CH-1:0] rx_drst_o,
    output logic [NUM_CH-1:0] cdr_ref_o,
    output logic [NUM_CH-1:0] cdr_data_o,
    output logic [NUM_CH-1:0] seq_done_o
);
    localparam int unsigned PD_CYC   = us_to_cycles(CLK_KHZ, PD_US);
    localparam int unsigned REF_CYC  = us_to_cycles(CLK_KHZ, REF_DWELL_US);
    localparam int unsigned DATA_CYC = us_to_cycles(CLK_KHZ, DATA_DWELL_US);
    localparam int unsigned NUM_SEQ  = BONDED ? 1 : NUM_CH;
    localparam int unsigned SW       = NUM_CH + 2;
    // busy resets to 1 (assume busy), locks reset to 0
    localparam logic [SW-1:0] SYNC_INIT = SW'(1) << NUM_CH;

    logic [SW-1:0]     sync_q;
    logic [NUM_CH-1:0] rx_lock_s;
    logic              busy_s;
    logic              tx_lock_s;
    logic              tx_run;
    logic              rx_hold;
    rx_ctl_t           ctl [NUM_SEQ];

    xcvr_sync2 #(.W(SW), .INIT(SYNC_INIT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({txpll_lock_i, cfg_busy_i, rxpll_lock_i}),
        .q_o (sync_q)
    );

    assign rx_lock_s = sync_q[NUM_CH-1:0];
    assign busy_s    = sync_q[NUM_CH];
    assign tx_lock_s = sync_q[NUM_CH+1];

    xcvr_tx_ctrl #(.PD_CYC(PD_CYC)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .lock_i (tx_lock_s),
        .pd_o   (txpll_pd_o),
        .run_o  (tx_run),
        .hold_o (rx_hold)
    );

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        logic lane_lock;
        if (BONDED) begin : g_all
            assign lane_lock = &rx_lock_s;
        end else begin : g_one
            assign lane_lock = rx_lock_s[s];
        end

        xcvr_rx_lane #(.REF_CYC(REF_CYC), .DATA_CYC(DATA_CYC)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .hold_i (rx_hold),
            .busy_i (busy_s),
            .lock_i (lane_lock),
            .ctl_o  (ctl[s])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned SEL = BONDED ? 0 : c;

        assign tx_rst_o[c]   = !tx_run;
        assign rx_arst_o[c]  = ctl[SEL].arst;
        assign rx_drst_o[c]  = ctl[SEL].drst;
        assign cdr_ref_o[c]  = ctl[SEL].cdr_ref;
        assign cdr_data_o[c] = ctl[SEL].cdr_data;
        assign seq_done_o[c] = ctl[SEL].done && tx_run;

        // R2: power-down keeps every channel control in its reset value
        a_r2_pd_holds_all: assert property (@(posedge clk) disable iff (rst)
            txpll_pd_o |-> (tx_rst_o[c] && rx_arst_o[c] && rx_drst_o[c] &&
                            cdr_ref_o[c] && !cdr_data_o[c]));

        // R3: transmit reset is released only after a synchronized lock
        a_r3_txrst_after_lock: assert property (@(posedge clk) disable iff (rst)
            $fell(tx_rst_o[c]) |-> $past(tx_lock_s));

        // R6: the two CDR mode controls are never both on or both off
        a_r6_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
            cdr_ref_o[c] != cdr_data_o[c]);

        // R9: done only with every reset released
        a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
            seq_done_o[c] |-> (!tx_rst_o[c] && !rx_arst_o[c] && !rx_drst_o[c]));
    end
endmodule

// File: tb/xcvr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_rst_seq_tb_top;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txlock = 1'b0;
    logic busy = 1'b1;
    logic [NCH-1:0] rxlock = '0;

    logic pd_b, pd_n;
    logic [NCH-1:0] txr_b, arst_b, drst_b, ref_b, dat_b, done_b;
    logic [NCH-1:0] txr_n, arst_n, drst_n, ref_n, dat_n, done_n;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Bonded instance
    xcvr_rst_seq #(.NUM_CH(NCH), .BONDED(1'b1), .CLK_KHZ(2500)) dut_i (
        .clk(clk), .rst(rst), .txpll_lock_i(txlock), .cfg_busy_i(busy),
        .rxpll_lock_i(rxlock), .txpll_pd_o(pd_b), .tx_rst_o(txr_b),
        .rx_arst_o(arst_b), .rx_drst_o(drst_b), .cdr_ref_o(ref_b),
        .cdr_data_o(dat_b), .seq_done_o(done_b));

    // Non-bonded instance on the same stimulus
    xcvr_rst_seq #(.NUM_CH(NCH), .BONDED(1'b0), .CLK_KHZ(2500)) dut_nb_i (
        .clk(clk), .rst(rst), .txpll_lock_i(txlock), .cfg_busy_i(busy),
        .rxpll_lock_i(rxlock), .txpll_pd_o(pd_n), .tx_rst_o(txr_n),
        .rx_arst_o(arst_n), .rx_drst_o(drst_n), .cdr_ref_o(ref_n),
        .cdr_data_o(dat_n), .seq_done_o(done_n));

    // Signal selectors: 0..6 bonded, 10..16 non-bonded
    localparam int S_PD = 0, S_TXR = 1, S_ARST = 2, S_DRST = 3,
                   S_REF = 4, S_DAT = 5, S_DONE = 6, NB = 10;

    function automatic bit probe(input int sel, input int ch);
        case (sel)
            S_PD:        return pd_b;
            S_TXR:       return txr_b[ch];
            S_ARST:      return arst_b[ch];
            S_DRST:      return drst_b[ch];
            S_REF:       return ref_b[ch];
            S_DAT:       return dat_b[ch];
            S_DONE:      return done_b[ch];
            NB + S_PD:   return pd_n;
            NB + S_TXR:  return txr_n[ch];
            NB + S_ARST: return arst_n[ch];
            NB + S_DRST: return drst_n[ch];
            NB + S_REF:  return ref_n[ch];
            NB + S_DAT:  return dat_n[ch];
            NB + S_DONE: return done_n[ch];
            default:     return 1'b0;
        endcase
    endfunction

    typedef struct {
        string tag;
        int    sel;
        int    ch;
        bit    lvl;
        int    edges;
    } exp_t;

    exp_t exp_q[$];
    int   mon_done = 0;

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input int sel, input int ch, input bit exp);
        bit got;
        got = probe(sel, ch);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s sel=%0d ch=%0d: actual=%0b expected=%0b", tag, sel, ch, got, exp);
        end
    endtask

    // Driver side: queue an expected edge count and wait for the monitor
    task automatic expect_edges(input string tag, input int sel, input int ch,
                                input bit lvl, input int edges);
        exp_t e;
        int   tgt;
        e.tag = tag; e.sel = sel; e.ch = ch; e.lvl = lvl; e.edges = edges;
        tgt = mon_done + 1;
        exp_q.push_back(e);
        wait (mon_done == tgt);
    endtask

    // Monitor: counts rising edges until the output reaches its level
    initial begin
        forever begin
            exp_t e;
            int   n;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            n = 0;
            do begin
                @(posedge clk);
                n++;
                #2;
            end while (probe(e.sel, e.ch) != e.lvl && n < 300);
            n_checks++;
            if (n != e.edges) begin
                n_errors++;
                $display("FAIL %s: actual=%0d edges expected=%0d edges", e.tag, n, e.edges);
            end
            @(negedge clk);
            mon_done++;
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state of both instances
        for (int d = 0; d <= NB; d += NB) begin
            chk("R1 pd in reset", d + S_PD, 0, 1'b1);
            for (int c = 0; c < NCH; c++) begin
                chk("R2 tx rst", d + S_TXR, c, 1'b1);
                chk("R2 arst", d + S_ARST, c, 1'b1);
                chk("R2 drst", d + S_DRST, c, 1'b1);
                chk("R2 cdr ref", d + S_REF, c, 1'b1);
                chk("R2 cdr data", d + S_DAT, c, 1'b0);
                chk("R9 done", d + S_DONE, c, 1'b0);
            end
        end

        rst = 1'b0;
        expect_edges("R1 R12 pd width 3", S_PD, 0, 1'b0, 3);
        chk("R1 nb pd released", NB + S_PD, 0, 1'b0);

        repeat (8) @(negedge clk);
        chk("R3 tx rst held without lock", S_TXR, 0, 1'b1);
        chk("R4 arst held while busy", S_ARST, 0, 1'b1);
        chk("R4 nb arst held while busy", NB + S_ARST, 1, 1'b1);

        txlock = 1'b1;
        expect_edges("R3 tx rst release", S_TXR, 0, 1'b0, 3);
        chk("R3 nb tx rst ch1", NB + S_TXR, 1, 1'b0);

        busy = 1'b0;
        expect_edges("R4 arst release", S_ARST, 0, 1'b0, 5);
        chk("R4 nb arst ch0", NB + S_ARST, 0, 1'b0);
        chk("R4 nb arst ch1", NB + S_ARST, 1, 1'b0);
        chk("R6 still ref mode", S_REF, 0, 1'b1);

        rxlock[0] = 1'b1;
        expect_edges("R8 R6 R12 nb ch0 data mode", NB + S_DAT, 0, 1'b1, 41);
        chk("R6 nb ch0 ref off", NB + S_REF, 0, 1'b0);
        expect_edges("R7 R12 nb ch0 drst", NB + S_DRST, 0, 1'b0, 10);
        chk("R9 nb ch0 done", NB + S_DONE, 0, 1'b1);
        chk("R8 nb ch1 waits", NB + S_DAT, 1, 1'b0);
        chk("R5 bonded waits for last lock", S_DAT, 0, 1'b0);
        chk("R5 bonded drst held", S_DRST, 1, 1'b1);

        rxlock[1] = 1'b1;
        expect_edges("R5 R6 bonded data mode", S_DAT, 0, 1'b1, 41);
        chk("R6 bonded ref off", S_REF, 1, 1'b0);
        chk("R5 bonded ch1 data", S_DAT, 1, 1'b1);
        expect_edges("R7 bonded drst", S_DRST, 1, 1'b0, 10);
        chk("R9 bonded done ch0", S_DONE, 0, 1'b1);
        chk("R9 bonded done ch1", S_DONE, 1, 1'b1);
        chk("R8 nb ch1 done", NB + S_DONE, 1, 1'b1);

        rxlock[1] = 1'b0;
        expect_edges("R10 bonded back to ref", S_DAT, 0, 1'b0, 3);
        chk("R10 ref on", S_REF, 0, 1'b1);
        chk("R10 drst on", S_DRST, 1, 1'b1);
        chk("R10 done off", S_DONE, 0, 1'b0);
        chk("R10 arst stays off", S_ARST, 0, 1'b0);
        chk("R10 nb ch0 unaffected", NB + S_DONE, 0, 1'b1);
        chk("R10 nb ch1 back to ref", NB + S_DAT, 1, 1'b0);

        rxlock[1] = 1'b1;
        expect_edges("R10 bonded regained", S_DONE, 0, 1'b1, 51);

        txlock = 1'b0;
        expect_edges("R11 pd on tx loss", S_PD, 0, 1'b1, 3);
        for (int d = 0; d <= NB; d += NB) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R11 tx rst", d + S_TXR, c, 1'b1);
                chk("R11 arst", d + S_ARST, c, 1'b1);
                chk("R11 drst", d + S_DRST, c, 1'b1);
                chk("R11 ref", d + S_REF, c, 1'b1);
                chk("R11 data", d + S_DAT, c, 1'b0);
                chk("R11 done", d + S_DONE, c, 1'b0);
            end
        end
        expect_edges("R1 pd width on restart", S_PD, 0, 1'b0, 3);

        txlock = 1'b1;
        expect_edges("R11 full rerun done", S_DONE, 1, 1'b1, 53);
        chk("R11 nb ch0 done", NB + S_DONE, 0, 1'b1);

        report();
    end
endmodule